// File: doc/BRIEF.md
# Clock Divider Setting Search Engine

This block works out the settings of a three-source clock generator that give an output rate as close as possible to a requested rate. A client places the requested rate and the current rates of the external reference and the two PLLs on the inputs, then pulses `start`. The engine tries every source and every predivider in turn. For each pair it derives the integer divider, works out the rate that setting would produce, and keeps the setting with the smallest error.

All the arithmetic stays in integers. Each source rate is doubled first, so the half-step predividers of 2, 2.5 and 3 become the whole numbers 4, 5 and 6. One shared restoring divider, which takes one cycle per dividend bit, does every division. When the search ends, `done` pulses for one cycle. The selected settings and the achieved rate then stay on the outputs until the next accepted `start`.

Top module: `clkdiv_search`

## Requirements
- R1: The request is first limited to the largest of the three source rates divided by 4 (integer floor). This limited value is the target for all later steps.
- R2: Candidates are visited in a fixed order: the external reference, then PLL1, then PLL2. Each source rate is doubled before use.
- R3: For each source the predivider takes the values 4, 5 and 6 in that order. The reported predivide code `preCode` equals the predivider minus 3.
- R4: The candidate divider is floor(2·source / (target·predivider)). A candidate whose divider is below 2 or above 127 is skipped. A reported `divVal` always lies in 2..127.
- R5: The achieved rate of a candidate is floor(2·source / (predivider·divider)).
- R6: A candidate replaces the kept setting only if no setting is kept yet, or if its absolute error against the target is strictly smaller. When two candidates have equal error, the earlier one in visiting order wins.
- R7: `srcPll` is 1 when either PLL wins. `srcPll2` is 1 only when PLL2 wins. Both are 0 when the external reference wins.
- R8: When no candidate is legal, `found` is 0 and `achRate`, `divVal`, `preCode`, `srcPll` and `srcPll2` are all 0.
- R9: A request of zero (or a target that the limit of R1 brings to zero) ends as a failure, with no search. `done` then comes at most 4 cycles after `start`.
- R10: A `start` pulse that arrives while `busy` is 1 is ignored. The running search finishes with the operands captured at its own start.
- R11: `busy` is 1 from the cycle after an accepted `start` up to and including the `done` cycle. `done` is high for exactly one cycle.
- R12: After reset, `busy`, `done` and `found` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Starts a search; sampled only while idle |
| reqRate | input | 32 | Requested output rate |
| extRate | input | 32 | External reference rate |
| pll1Rate | input | 32 | PLL1 rate |
| pll2Rate | input | 32 | PLL2 rate |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle pulse: results valid |
| found | output | 1 | A legal setting was found |
| srcPll | output | 1 | Winning source is a PLL |
| srcPll2 | output | 1 | Winning source is PLL2 |
| preCode | output | 2 | Predivider minus 3 |
| divVal | output | 7 | Integer divider |
| achRate | output | 32 | Achieved rate, 0 on failure |

## Verification
The bench targets four corner cases:
- **Ties between identical sources.** Giving all three sources the same rate makes their candidates tie. A design that replaces the kept setting on equal error would report a PLL instead of the external reference.
- **Requests far above any source.** A request of all ones must be limited to the largest source divided by 4. Without the limit, every divider would fall below 2 and the search would fail.
- **Failing requests.** A tiny request makes every divider exceed 127, and a zero request must fail at once. Either one would expose stale outputs or a hung search.
- **Start while busy.** A second `start` with a different request arrives in the middle of a search. A design that re-captures its operands would return the wrong setting.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  localparam int PRE_FIRST = 4;
  localparam int PRE_LAST  = 6;
  localparam int NUM_SRC   = 3;

  typedef struct packed {
    logic       capture;    // latch operands, clear kept setting
    logic       divGo;      // launch the shared divider
    logic       divSecond;  // 0: find divider, 1: find achieved rate
    logic       takeCand;   // latch candidate divider from quotient
    logic       updBest;    // candidate becomes kept setting
    logic [1:0] srcIdx;     // 0 ext, 1 pll1, 2 pll2
    logic [2:0] preVal;     // predivider applied to doubled rate
  } ctlStrobe_t;
endpackage

// File: rtl/clkdiv_divider.sv
module clkdiv_divider #(
  parameter int N = 33,
  parameter int M = 35
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         go,
  input  logic [N-1:0] dividend,
  input  logic [M-1:0] divisor,
  output logic [N-1:0] quotient,
  output logic         doneP
);
  localparam int CW = $clog2(N + 1);

  logic [M-1:0]  remQ;
  logic [M-1:0]  dvsQ;
  logic [N-1:0]  quoQ;
  logic [CW-1:0] cntQ;
  logic          activeQ;
  logic [M:0]    trial;
  logic          fits;

  assign trial = {remQ, quoQ[N-1]};
  assign fits  = trial >= {1'b0, dvsQ};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remQ    <= '0;
      dvsQ    <= '0;
      quoQ    <= '0;
      cntQ    <= '0;
      activeQ <= 1'b0;
      doneP   <= 1'b0;
    end else begin
      doneP <= 1'b0;
      if (go) begin
        remQ    <= '0;
        dvsQ    <= divisor;
        quoQ    <= dividend;
        cntQ    <= CW'(N);
        activeQ <= 1'b1;
      end else if (activeQ) begin
        remQ <= fits ? M'(trial - {1'b0, dvsQ}) : trial[M-1:0];
        quoQ <= {quoQ[N-2:0], fits};
        cntQ <= cntQ - 1'b1;
        if (cntQ == CW'(1)) begin
          activeQ <= 1'b0;
          doneP   <= 1'b1;
        end
      end
    end
  end

  assign quotient = quoQ;

  // R5: a finished division leaves a remainder smaller than its divisor
  p_rem_bound_r5: assert property (@(posedge clk) disable iff (!rstN)
    doneP |-> (remQ < dvsQ));
endmodule

// File: rtl/clkdiv_ctrl.sv
module clkdiv_ctrl
  import clkdiv_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       rateZero,
  input  logic       divDone,
  input  logic       quoLegal,
  input  logic       isBetter,
  output ctlStrobe_t ctl,
  output logic       busy,
  output logic       done
);
  typedef enum logic [3:0] {
    S_IDLE, S_CHKZ, S_GO1, S_DIV1, S_CHK1, S_GO2, S_DIV2, S_CMP, S_ADV, S_FIN
  } state_t;

  state_t     stateQ, stateD;
  logic [1:0] srcQ;
  logic [2:0] preQ;
  logic       lastCand;

  assign lastCand = (srcQ == 2'(NUM_SRC - 1)) && (preQ == 3'(PRE_LAST));

  always_comb begin
    stateD        = stateQ;
    ctl           = '0;
    ctl.srcIdx    = srcQ;
    ctl.preVal    = preQ;
    unique case (stateQ)
      S_IDLE: if (start) begin
        ctl.capture = 1'b1;
        stateD      = S_CHKZ;
      end
      S_CHKZ: stateD = rateZero ? S_FIN : S_GO1;
      S_GO1: begin
        ctl.divGo = 1'b1;
        stateD    = S_DIV1;
      end
      S_DIV1: if (divDone) stateD = S_CHK1;
      S_CHK1: if (quoLegal) begin
        ctl.takeCand = 1'b1;
        stateD       = S_GO2;
      end else begin
        stateD = S_ADV;
      end
      S_GO2: begin
        ctl.divGo     = 1'b1;
        ctl.divSecond = 1'b1;
        stateD        = S_DIV2;
      end
      S_DIV2: if (divDone) stateD = S_CMP;
      S_CMP: begin
        ctl.updBest = isBetter;
        stateD      = S_ADV;
      end
      S_ADV: stateD = lastCand ? S_FIN : S_GO1;
      S_FIN: stateD = S_IDLE;
      default: stateD = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= S_IDLE;
      srcQ   <= '0;
      preQ   <= 3'(PRE_FIRST);
    end else begin
      stateQ <= stateD;
      if (ctl.capture) begin
        srcQ <= '0;
        preQ <= 3'(PRE_FIRST);
      end else if (stateQ == S_ADV && !lastCand) begin
        if (preQ == 3'(PRE_LAST)) begin
          preQ <= 3'(PRE_FIRST);
          srcQ <= srcQ + 1'b1;
        end else begin
          preQ <= preQ + 1'b1;
        end
      end
    end
  end

  assign busy = (stateQ != S_IDLE);
  assign done = (stateQ == S_FIN);

  // R11: done never lasts two cycles
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  // R11: done only ever appears while busy
  p_done_busy_r11: assert property (@(posedge clk) disable iff (!rstN)
    done |-> busy);
  // R3: predivider stays inside its visiting range
  p_pre_range_r3: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (preQ >= 3'(PRE_FIRST) && preQ <= 3'(PRE_LAST)));
endmodule

// File: rtl/clkdiv_dp.sv
module clkdiv_dp
  import clkdiv_pkg::*;
#(
  parameter int W       = 32,
  parameter int DIVW    = 7,
  parameter int DIV_MIN = 2,
  parameter int DIV_MAX = 127
) (
  input  logic            clk,
  input  logic            rstN,
  input  ctlStrobe_t      ctl,
  input  logic [W-1:0]    reqRate,
  input  logic [W-1:0]    extRate,
  input  logic [W-1:0]    pll1Rate,
  input  logic [W-1:0]    pll2Rate,
  output logic            rateZero,
  output logic            divDone,
  output logic            quoLegal,
  output logic            isBetter,
  output logic            found,
  output logic            srcPll,
  output logic            srcPll2,
  output logic [1:0]      preCode,
  output logic [DIVW-1:0] divVal,
  output logic [W-1:0]    achRate
);
  localparam int N = W + 1;   // doubled source width
  localparam int M = W + 3;   // target times predivider

  logic [W-1:0]    srcQ [NUM_SRC];
  logic [N-1:0]    dbl  [NUM_SRC];
  logic [W-1:0]    rateQ;
  logic [W-1:0]    maxSrc, limit, clamped;
  logic [DIVW-1:0] candQ;
  logic [N-1:0]    quo;
  logic [M-1:0]    divisor;
  logic [N-1:0]    err;
  logic [N-1:0]    bestErrQ;
  logic [W-1:0]    bestRateQ;
  logic [DIVW-1:0] bestDivQ;
  logic [1:0]      bestPreQ;
  logic [1:0]      bestSrcQ;
  logic            haveQ;

  always_comb begin
    maxSrc = extRate;
    if (pll1Rate > maxSrc) maxSrc = pll1Rate;
    if (pll2Rate > maxSrc) maxSrc = pll2Rate;
    limit   = maxSrc >> 2;
    clamped = (reqRate < limit) ? reqRate : limit;
  end

  generate
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_dbl
      assign dbl[g] = {srcQ[g], 1'b0};
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_SRC; i++) srcQ[i] <= '0;
      rateQ <= '0;
    end else if (ctl.capture) begin
      srcQ[0] <= extRate;
      srcQ[1] <= pll1Rate;
      srcQ[2] <= pll2Rate;
      rateQ   <= clamped;
    end
  end

  assign rateZero = (rateQ == '0);
  assign divisor  = ctl.divSecond ? M'(ctl.preVal) * M'(candQ)
                                  : M'(rateQ) * M'(ctl.preVal);

  clkdiv_divider #(.N(N), .M(M)) u_div (
    .clk      (clk),
    .rstN     (rstN),
    .go       (ctl.divGo),
    .dividend (dbl[ctl.srcIdx]),
    .divisor  (divisor),
    .quotient (quo),
    .doneP    (divDone)
  );

  assign quoLegal = (quo >= N'(DIV_MIN)) && (quo <= N'(DIV_MAX));
  assign err      = (quo >= {1'b0, rateQ}) ? quo - {1'b0, rateQ}
                                           : {1'b0, rateQ} - quo;
  assign isBetter = !haveQ || (err < bestErrQ);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      candQ     <= '0;
      bestErrQ  <= '0;
      bestRateQ <= '0;
      bestDivQ  <= '0;
      bestPreQ  <= '0;
      bestSrcQ  <= '0;
      haveQ     <= 1'b0;
    end else begin
      if (ctl.takeCand) candQ <= quo[DIVW-1:0];
      if (ctl.capture) begin
        bestErrQ  <= '0;
        bestRateQ <= '0;
        bestDivQ  <= '0;
        bestPreQ  <= '0;
        bestSrcQ  <= '0;
        haveQ     <= 1'b0;
      end else if (ctl.updBest) begin
        bestErrQ  <= err;
        bestRateQ <= quo[W-1:0];
        bestDivQ  <= candQ;
        bestPreQ  <= 2'(ctl.preVal - 3'd3);
        bestSrcQ  <= ctl.srcIdx;
        haveQ     <= 1'b1;
      end
    end
  end

  assign found   = haveQ;
  assign achRate = bestRateQ;
  assign divVal  = bestDivQ;
  assign preCode = bestPreQ;
  assign srcPll  = haveQ && (bestSrcQ != 2'd0);
  assign srcPll2 = haveQ && (bestSrcQ == 2'd2);

  // R4: a kept candidate always carries a divider in the legal range
  p_legal_div_r4: assert property (@(posedge clk) disable iff (!rstN)
    ctl.updBest |-> (candQ >= DIVW'(DIV_MIN) && candQ <= DIVW'(DIV_MAX)));
  // R6: each replacement strictly lowers the kept error
  p_err_drops_r6: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.updBest && haveQ) |=> (bestErrQ < $past(bestErrQ)));
  // R10: operands change only on an accepted start
  p_rate_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.capture |=> $stable(rateQ));
  // R1: the captured target never exceeds the limit of its own inputs
  p_clamp_r1: assert property (@(posedge clk) disable iff (!rstN)
    ctl.capture |-> (clamped <= reqRate && clamped <= limit));
endmodule

// File: rtl/clkdiv_search.sv
module clkdiv_search #(
  parameter int W    = 32,
  parameter int DIVW = 7
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            start,
  input  logic [W-1:0]    reqRate,
  input  logic [W-1:0]    extRate,
  input  logic [W-1:0]    pll1Rate,
  input  logic [W-1:0]    pll2Rate,
  output logic            busy,
  output logic            done,
  output logic            found,
  output logic            srcPll,
  output logic            srcPll2,
  output logic [1:0]      preCode,
  output logic [DIVW-1:0] divVal,
  output logic [W-1:0]    achRate
);
  import clkdiv_pkg::*;

  ctlStrobe_t ctl;
  logic rateZero, divDone, quoLegal, isBetter;

  clkdiv_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .rateZero (rateZero),
    .divDone  (divDone),
    .quoLegal (quoLegal),
    .isBetter (isBetter),
    .ctl      (ctl),
    .busy     (busy),
    .done     (done)
  );

  clkdiv_dp #(.W(W), .DIVW(DIVW)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .reqRate  (reqRate),
    .extRate  (extRate),
    .pll1Rate (pll1Rate),
    .pll2Rate (pll2Rate),
    .rateZero (rateZero),
    .divDone  (divDone),
    .quoLegal (quoLegal),
    .isBetter (isBetter),
    .found    (found),
    .srcPll   (srcPll),
    .srcPll2  (srcPll2),
    .preCode  (preCode),
    .divVal   (divVal),
    .achRate  (achRate)
  );

  // R7: PLL2 selection implies PLL selection
  p_sel_pair_r7: assert property (@(posedge clk) disable iff (!rstN)
    srcPll2 |-> srcPll);
  // R8: a failed search leaves the achieved rate at zero
  p_fail_zero_r8: assert property (@(posedge clk) disable iff (!rstN)
    (done && !found) |-> (achRate == '0 && divVal == '0));
endmodule

// File: tb/sim_clkdiv_search.sv
`timescale 1ns/1ps
module sim_clkdiv_search;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [31:0] reqRate = '0, extRate = '0, pll1Rate = '0, pll2Rate = '0;
  logic        busy, done, found, srcPll, srcPll2;
  logic [1:0]  preCode;
  logic [6:0]  divVal;
  logic [31:0] achRate;

  int nChecks = 0;
  int nFail   = 0;

  always #4 clk = ~clk;

  clkdiv_search u0 (
    .clk(clk), .rstN(rstN), .start(start), .reqRate(reqRate),
    .extRate(extRate), .pll1Rate(pll1Rate), .pll2Rate(pll2Rate),
    .busy(busy), .done(done), .found(found), .srcPll(srcPll),
    .srcPll2(srcPll2), .preCode(preCode), .divVal(divVal), .achRate(achRate)
  );

  task automatic check(input string req, input string what,
                       input longint act, input longint exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // reference built from the requirements
  longint eFound, eEsel, ePsel, eCode, eDiv, eAch;
  task automatic model(input longint req, input longint e, input longint p1,
                       input longint p2);
    longint mx, r, m, d, a, er, bestEr;
    mx = e;
    if (p1 > mx) mx = p1;
    if (p2 > mx) mx = p2;
    mx = mx / 4;
    r = (req < mx) ? req : mx;
    eFound = 0; eEsel = 0; ePsel = 0; eCode = 0; eDiv = 0; eAch = 0;
    bestEr = 0;
    if (r == 0) return;
    for (int i = 0; i < 3; i++) begin
      m = 2 * ((i == 0) ? e : (i == 1) ? p1 : p2);
      for (int p = 4; p <= 6; p++) begin
        d = m / (r * p);
        if (d < 2 || d > 127) continue;
        a = m / (p * d);
        er = (a > r) ? a - r : r - a;
        if (eFound == 0 || er < bestEr) begin
          eFound = 1; eEsel = (i != 0); ePsel = (i == 2);
          eCode = p - 3; eDiv = d; eAch = a; bestEr = er;
        end
      end
    end
  endtask

  task automatic pulseStart();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic waitDone(input string req, output int cyc);
    cyc = 0;
    while (!done && cyc < 3000) begin
      @(negedge clk); cyc++;
    end
    check(req, "done seen", done, 1);
  endtask

  task automatic compareAll(input string req);
    check(req, "found", found, eFound);
    check(req, "srcPll", srcPll, eEsel);
    check(req, "srcPll2", srcPll2, ePsel);
    check(req, "preCode", preCode, eCode);
    check(req, "divVal", divVal, eDiv);
    check(req, "achRate", achRate, eAch);
  endtask

  task automatic runCase(input string req, input longint r, input longint e,
                         input longint p1, input longint p2);
    int cyc;
    reqRate = 32'(r); extRate = 32'(e); pll1Rate = 32'(p1); pll2Rate = 32'(p2);
    model(r, e, p1, p2);
    pulseStart();
    check("R11", "busy after start", busy, 1);
    waitDone(req, cyc);
    compareAll(req);
    @(negedge clk);
    check("R11", "done one cycle", done, 0);
    check("R11", "idle after done", busy, 0);
    compareAll(req);
  endtask

  task automatic testReset();
    check("R12", "busy", busy, 0);
    check("R12", "done", done, 0);
    check("R12", "found", found, 0);
  endtask

  task automatic testTypical();
    // R2 R3 R4 R5 R6
    runCase("R6", 25000000, 14745600, 400000000, 192000000);
    runCase("R5", 31500000, 14745600, 300000000, 384000000);
  endtask

  task automatic testClamp();
    // R1: request far above every source is limited to max/4
    runCase("R1", 64'hFFFF_FFFF, 14745600, 400000000, 192000000);
    check("R1", "achRate clamp", achRate, 100000000);
  endtask

  task automatic testTie();
    // R6: identical sources tie, the external reference wins
    runCase("R6", 7000000, 100000000, 100000000, 100000000);
    check("R2", "ext wins tie", srcPll, 0);
  endtask

  task automatic testPll2();
    // R7: only PLL2 can reach the request
    runCase("R7", 90000000, 1000000, 2000000, 360000000);
    check("R7", "srcPll2", srcPll2, 1);
    check("R7", "srcPll", srcPll, 1);
  endtask

  task automatic testNoLegal();
    // R8: every divider is above 127
    runCase("R8", 1000, 14745600, 400000000, 192000000);
    check("R8", "found", found, 0);
    check("R8", "achRate", achRate, 0);
  endtask

  task automatic testZero();
    int cyc;
    reqRate = 0; extRate = 14745600; pll1Rate = 400000000; pll2Rate = 192000000;
    pulseStart();
    waitDone("R9", cyc);
    check("R9", "fast done", (cyc <= 3) ? 1 : 0, 1);
    check("R9", "found", found, 0);
    check("R9", "achRate", achRate, 0);
    @(negedge clk);
  endtask

  task automatic testBusyStart();
    int cyc;
    reqRate = 25000000; extRate = 14745600; pll1Rate = 400000000;
    pll2Rate = 192000000;
    model(25000000, 14745600, 400000000, 192000000);
    pulseStart();
    repeat (20) @(negedge clk);
    reqRate = 1000000;
    start = 1'b1;
    @(negedge clk); start = 1'b0;
    waitDone("R10", cyc);
    compareAll("R10");
    @(negedge clk);
    check("R10", "no second run", busy, 0);
  endtask

  initial begin
    #1000000;
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testTypical();
    testClamp();
    testTie();
    testPll2();
    testNoLegal();
    testZero();
    testBusyStart();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule